// File: doc/BRIEF.md
# Pin Routing Cell with Multiplexer and Three Storage Elements

This block is the per-pin cell of a bus-switching fabric. A multiplexer picks one of four routed data words, and the choice feeds an output storage element that drives the pin. A second storage element holds the pin's output enable and runs off the same clock as the output element, so a new data word and its enable reach the pin on the same edge. A third storage element captures the pin's incoming value on a clock and enable of its own, so the capture side runs apart from the drive side.

Each of the three elements works either as an edge-triggered flop or as a level-sensitive latch, chosen by a mode input. Each has a clock enable, a local set and a local reset, and a chip-wide active-low reset clears it. The output and input elements can also load from the cell below (index n-1) or the cell above (index n+1) in a row. A row of cells wired this way forms a shift chain that runs in either direction, which is how serializers and deserializers are built out of plain routing cells.

Top module: `mrb_cell`

## Requirements
- R1: With the output element in flop mode, shift mode 00, clock enable high and no set or reset, `pin_out` takes data slice `mux_sel` of `mux_src` (slice k is bits [k*DW +: DW]) at the next rising edge of `clk_out`.
- R2: `pin_oe` takes `oe_d` at the same rising edge of `clk_out` that updates `pin_out`.
- R3: `in_q` takes `in_d` at the next rising edge of `clk_in` when `in_ce` is high, whatever the output element's enable is doing.
- R4: With its clock enable low and no set or reset, an element keeps its value across clock edges even as its data inputs change.
- R5: In latch mode an element passes its selected source through while its clock is high and holds its value while its clock is low.
- R6: Shift mode 01 loads the element from its n-1 neighbour input, 10 loads it from its n+1 neighbour input, and 11 leaves it unchanged; this applies to both the output and the input elements.
- R7: A local set loads all ones and a local reset loads all zeros, whatever the clock enable; when both are high, the reset wins.
- R8: With `rst_n` low at a rising edge, all three elements clear to zero, over any set, enable or data input.
- R9: After reset, `pin_out`, `pin_oe` and `in_q` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_out | input | 1 | Clock for the output and output-enable elements |
| clk_in | input | 1 | Clock for the input element |
| rst_n | input | 1 | Chip-wide active-low reset, taken at the active clock phase |
| mux_src | input | NSEL*DW | Routed data words, word k in bits [k*DW +: DW] |
| mux_sel | input | SELW | Index of the routed word sent to the output element |
| out_ce | input | 1 | Output element clock enable |
| out_set | input | 1 | Output element set to all ones |
| out_rst | input | 1 | Output element reset to zero, wins over set |
| out_latch | input | 1 | Output element latch mode when high, flop when low |
| out_shift | input | 2 | Output element source: 00 mux, 01 n-1, 10 n+1, 11 hold |
| out_from_lo | input | DW | Output value of neighbour n-1 |
| out_from_hi | input | DW | Output value of neighbour n+1 |
| oe_d | input | 1 | Output enable to be captured |
| oe_ce | input | 1 | Output-enable element clock enable |
| oe_set | input | 1 | Output-enable element set |
| oe_rst | input | 1 | Output-enable element reset, wins over set |
| oe_latch | input | 1 | Output-enable element latch mode |
| in_d | input | DW | Value arriving from the pin |
| in_ce | input | 1 | Input element clock enable |
| in_set | input | 1 | Input element set to all ones |
| in_rst | input | 1 | Input element reset, wins over set |
| in_latch | input | 1 | Input element latch mode |
| in_shift | input | 2 | Input element source: 00 pin, 01 n-1, 10 n+1, 11 hold |
| in_from_lo | input | DW | Captured input of neighbour n-1 |
| in_from_hi | input | DW | Captured input of neighbour n+1 |
| pin_out | output | DW | Data driven toward the pin |
| pin_oe | output | 1 | Output enable for the pin driver |
| in_q | output | DW | Captured pin value, also sent to neighbours |

## Verification
In flop mode every result is due at the first rising edge after the stimulus, one register deep. The bench therefore drives inputs on a falling edge and reads outputs on the next falling edge, half a period after the capturing edge. Latch-mode results are due while the clock is high, so those checks read the output one nanosecond after each source change inside the high phase. A further change made just after the falling edge confirms that the value holds. Set, reset and shift results follow the flop timing, and the global reset is checked one edge after `rst_n` goes low while sets are also asserted.

// File: rtl/mrb_pkg.sv
// Shared types for the pin routing cell.
// Assumes: source selection codes are two bits wide.
package mrb_pkg;

    // Source selection for a storage element
    typedef enum logic [1:0] {
        SRC_NORM = 2'b00,   // normal data path
        SRC_LO   = 2'b01,   // neighbour at index n-1
        SRC_HI   = 2'b10,   // neighbour at index n+1
        SRC_HOLD = 2'b11    // no load
    } src_sel_e;

endpackage

// File: rtl/mrb_mux.sv
// Generic N:1 word multiplexer feeding the output element.
// Assumes: NSEL >= 2; the source words are packed, word k at [k*DW +: DW].
module mrb_mux #(
    parameter int NSEL = 4,
    parameter int DW   = 1,
    localparam int SELW = $clog2(NSEL)
) (
    input  logic [NSEL*DW-1:0] src,
    input  logic [SELW-1:0]    sel,
    output logic [DW-1:0]      y
);

    logic [DW-1:0] words [NSEL];

    // unpack the flat source bus into words
    for (genvar k = 0; k < NSEL; k++) begin : g_unpack
        assign words[k] = src[k*DW +: DW];
    end

    // pick the word whose index matches the select
    always_comb begin
        y = '0;
        for (int k = 0; k < NSEL; k++) begin
            if (sel == k[SELW-1:0]) y = words[k];
        end
    end

endmodule

// File: rtl/mrb_store.sv
// One storage element: flop or transparent-high latch, chosen by latch_mode.
// Priority: rst_n low, then local reset, then local set, then enabled load.
// The load source is normal data, neighbour n-1 or n+1, or nothing (hold).
// Assumes: latch_mode is held steady around the clock edges it is used on.
module mrb_store
    import mrb_pkg::*;
#(
    parameter int DW = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          latch_mode,
    input  logic          ce,
    input  logic          set_i,
    input  logic          rst_i,
    input  logic [1:0]    shift_mode,
    input  logic [DW-1:0] d_norm,
    input  logic [DW-1:0] d_lo,
    input  logic [DW-1:0] d_hi,
    output logic [DW-1:0] q
);

    logic [DW-1:0] src;
    logic          load;
    logic [DW-1:0] nxt;
    logic [DW-1:0] flop_q;
    logic [DW-1:0] latch_q;

    // choose the load source and whether a load happens
    always_comb begin
        unique case (src_sel_e'(shift_mode))
            SRC_LO:   begin src = d_lo;   load = ce;   end
            SRC_HI:   begin src = d_hi;   load = ce;   end
            SRC_HOLD: begin src = d_norm; load = 1'b0; end
            default:  begin src = d_norm; load = ce;   end
        endcase
    end

    // next value by priority: global reset, local reset, set, load, hold
    always_comb begin
        if (!rst_n)     nxt = '0;
        else if (rst_i) nxt = '0;
        else if (set_i) nxt = '1;
        else if (load)  nxt = src;
        else            nxt = q;
    end

    // edge-triggered variant
    always_ff @(posedge clk) begin
        flop_q <= nxt;
    end

    // level-sensitive variant, transparent while the clock is high
    always_latch begin
        if (clk) latch_q <= nxt;
    end

    // present the variant the mode selects
    assign q = latch_mode ? latch_q : flop_q;

    AST_RST_OVER_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (!latch_mode && rst_i) |=> (latch_mode || q == '0));                       // R7
    AST_SET_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (!latch_mode && set_i && !rst_i) |=> (latch_mode || q == '1));            // R7
    AST_HOLD_NO_CE: assert property (@(posedge clk) disable iff (!rst_n)
        (!latch_mode && !ce && !set_i && !rst_i) |=> (latch_mode || $stable(q))); // R4
    AST_SHIFT_LO: assert property (@(posedge clk) disable iff (!rst_n)
        (!latch_mode && ce && !set_i && !rst_i && shift_mode == 2'b01)
        |=> (latch_mode || q == $past(d_lo)));                                    // R6
    AST_SHIFT_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (!latch_mode && ce && !set_i && !rst_i && shift_mode == 2'b10)
        |=> (latch_mode || q == $past(d_hi)));                                    // R6
    AST_SHIFT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!latch_mode && !set_i && !rst_i && shift_mode == 2'b11)
        |=> (latch_mode || $stable(q)));                                          // R6

endmodule

// File: rtl/mrb_cell.sv
// Per-pin routing cell: a 4:1 mux feeds the output element; an
// output-enable element shares its clock; an input element captures the pin
// on its own clock. Output and input elements chain to neighbours n-1, n+1.
// Assumes: neighbour ports are wired to the adjacent cells' pin_out / in_q.
module mrb_cell
    import mrb_pkg::*;
#(
    parameter int NSEL = 4,
    parameter int DW   = 1,
    localparam int SELW = $clog2(NSEL)
) (
    input  logic               clk_out,
    input  logic               clk_in,
    input  logic               rst_n,
    input  logic [NSEL*DW-1:0] mux_src,
    input  logic [SELW-1:0]    mux_sel,
    input  logic               out_ce,
    input  logic               out_set,
    input  logic               out_rst,
    input  logic               out_latch,
    input  logic [1:0]         out_shift,
    input  logic [DW-1:0]      out_from_lo,
    input  logic [DW-1:0]      out_from_hi,
    input  logic               oe_d,
    input  logic               oe_ce,
    input  logic               oe_set,
    input  logic               oe_rst,
    input  logic               oe_latch,
    input  logic [DW-1:0]      in_d,
    input  logic               in_ce,
    input  logic               in_set,
    input  logic               in_rst,
    input  logic               in_latch,
    input  logic [1:0]         in_shift,
    input  logic [DW-1:0]      in_from_lo,
    input  logic [DW-1:0]      in_from_hi,
    output logic [DW-1:0]      pin_out,
    output logic               pin_oe,
    output logic [DW-1:0]      in_q
);

    logic [DW-1:0] mux_y;

    // route one of the words toward the output element
    mrb_mux #(.NSEL(NSEL), .DW(DW)) u_mux (
        .src (mux_src),
        .sel (mux_sel),
        .y   (mux_y)
    );

    // output element, drives the pin
    mrb_store #(.DW(DW)) u_out (
        .clk        (clk_out),
        .rst_n      (rst_n),
        .latch_mode (out_latch),
        .ce         (out_ce),
        .set_i      (out_set),
        .rst_i      (out_rst),
        .shift_mode (out_shift),
        .d_norm     (mux_y),
        .d_lo       (out_from_lo),
        .d_hi       (out_from_hi),
        .q          (pin_out)
    );

    // output-enable element, same clock as the output element, no chain
    mrb_store #(.DW(1)) u_oe (
        .clk        (clk_out),
        .rst_n      (rst_n),
        .latch_mode (oe_latch),
        .ce         (oe_ce),
        .set_i      (oe_set),
        .rst_i      (oe_rst),
        .shift_mode (SRC_NORM),
        .d_norm     (oe_d),
        .d_lo       (1'b0),
        .d_hi       (1'b0),
        .q          (pin_oe)
    );

    // input element, captures the pin on its own clock
    mrb_store #(.DW(DW)) u_in (
        .clk        (clk_in),
        .rst_n      (rst_n),
        .latch_mode (in_latch),
        .ce         (in_ce),
        .set_i      (in_set),
        .rst_i      (in_rst),
        .shift_mode (in_shift),
        .d_norm     (in_d),
        .d_lo       (in_from_lo),
        .d_hi       (in_from_hi),
        .q          (in_q)
    );

    AST_OUT_FOLLOWS_MUX: assert property (@(posedge clk_out) disable iff (!rst_n)
        (!out_latch && out_ce && !out_set && !out_rst && out_shift == 2'b00)
        |=> (out_latch || pin_out == $past(mux_src[mux_sel*DW +: DW])));           // R1
    AST_OE_SAME_EDGE: assert property (@(posedge clk_out) disable iff (!rst_n)
        (!oe_latch && oe_ce && !oe_set && !oe_rst)
        |=> (oe_latch || pin_oe == $past(oe_d)));                                  // R2
    AST_IN_CAPTURE: assert property (@(posedge clk_in) disable iff (!rst_n)
        (!in_latch && in_ce && !in_set && !in_rst && in_shift == 2'b00)
        |=> (in_latch || in_q == $past(in_d)));                                    // R3

endmodule

// File: tb/tb_mrb_cell.sv
module tb_mrb_cell;

    localparam int NSEL = 4;
    localparam int DW   = 4;
    localparam int SELW = $clog2(NSEL);

    logic clk = 1'b0;
    always #4 clk = ~clk;  // 125 MHz

    logic               rst_n;
    logic [NSEL*DW-1:0] mux_src;
    logic [SELW-1:0]    mux_sel;
    logic               out_ce, out_set, out_rst, out_latch;
    logic [1:0]         out_shift;
    logic [DW-1:0]      out_from_lo, out_from_hi;
    logic               oe_d, oe_ce, oe_set, oe_rst, oe_latch;
    logic [DW-1:0]      in_d;
    logic               in_ce, in_set, in_rst, in_latch;
    logic [1:0]         in_shift;
    logic [DW-1:0]      in_from_lo, in_from_hi;
    logic [DW-1:0]      pin_out;
    logic               pin_oe;
    logic [DW-1:0]      in_q;

    mrb_cell #(.NSEL(NSEL), .DW(DW)) dut (
        .clk_out(clk), .clk_in(clk), .rst_n(rst_n),
        .mux_src(mux_src), .mux_sel(mux_sel),
        .out_ce(out_ce), .out_set(out_set), .out_rst(out_rst),
        .out_latch(out_latch), .out_shift(out_shift),
        .out_from_lo(out_from_lo), .out_from_hi(out_from_hi),
        .oe_d(oe_d), .oe_ce(oe_ce), .oe_set(oe_set), .oe_rst(oe_rst),
        .oe_latch(oe_latch),
        .in_d(in_d), .in_ce(in_ce), .in_set(in_set), .in_rst(in_rst),
        .in_latch(in_latch), .in_shift(in_shift),
        .in_from_lo(in_from_lo), .in_from_hi(in_from_hi),
        .pin_out(pin_out), .pin_oe(pin_oe), .in_q(in_q)
    );

    // {sel, src, oe_d, in_d, exp pin_out, exp pin_oe, exp in_q}
    localparam logic [31:0] VEC [6] = '{
        {2'd0, 16'hA5C3, 1'b1, 4'h6, 4'h3, 1'b1, 4'h6},
        {2'd1, 16'hA5C3, 1'b0, 4'h9, 4'hC, 1'b0, 4'h9},
        {2'd2, 16'hA5C3, 1'b1, 4'hF, 4'h5, 1'b1, 4'hF},
        {2'd3, 16'hA5C3, 1'b1, 4'h0, 4'hA, 1'b1, 4'h0},
        {2'd2, 16'h1234, 1'b0, 4'h5, 4'h2, 1'b0, 4'h5},
        {2'd1, 16'hF0E1, 1'b1, 4'hA, 4'hE, 1'b1, 4'hA}
    };

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic quiet();
        out_ce = 1'b0; out_set = 1'b0; out_rst = 1'b0; out_latch = 1'b0; out_shift = 2'b00;
        oe_ce = 1'b0; oe_set = 1'b0; oe_rst = 1'b0; oe_latch = 1'b0;
        in_ce = 1'b0; in_set = 1'b0; in_rst = 1'b0; in_latch = 1'b0; in_shift = 2'b00;
    endtask

    // watchdog
    initial begin
        #(200000 * 8);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; mux_src = '0; mux_sel = '0; oe_d = 1'b0; in_d = '0;
        out_from_lo = '0; out_from_hi = '0; in_from_lo = '0; in_from_hi = '0;
        quiet();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R9: reset state
        check("R9 pin_out", 32'(pin_out), 32'h0);
        check("R9 pin_oe",  32'(pin_oe),  32'h0);
        check("R9 in_q",    32'(in_q),    32'h0);

        // R1 R2 R3: table walk, flop mode, drive on falling edge, read one edge later
        out_ce = 1'b1; oe_ce = 1'b1; in_ce = 1'b1;
        for (int i = 0; i < 6; i++) begin
            mux_sel = VEC[i][31:30]; mux_src = VEC[i][29:14];
            oe_d = VEC[i][13]; in_d = VEC[i][12:9];
            @(negedge clk);
            check("R1 mux to pin_out", 32'(pin_out), 32'(VEC[i][8:5]));
            check("R2 oe same edge",   32'(pin_oe),  32'(VEC[i][4]));
            check("R3 input capture",  32'(in_q),    32'(VEC[i][3:0]));
        end

        // R4 and R3 independence: output side disabled, input side loads
        out_ce = 1'b0; oe_ce = 1'b0; in_ce = 1'b1;
        mux_src = 16'h7777; oe_d = 1'b0; in_d = 4'h3;
        @(negedge clk);
        check("R4 pin_out held",  32'(pin_out), 32'hE);
        check("R4 pin_oe held",   32'(pin_oe),  32'h1);
        check("R3 in_q loads alone", 32'(in_q), 32'h3);
        in_ce = 1'b0; in_d = 4'hC;
        @(negedge clk);
        check("R4 in_q held", 32'(in_q), 32'h3);

        // R7: set with enable low, then set and reset together
        out_set = 1'b1; oe_set = 1'b1; in_set = 1'b1;
        @(negedge clk);
        check("R7 out set", 32'(pin_out), 32'hF);
        check("R7 in set",  32'(in_q),    32'hF);
        out_rst = 1'b1; oe_rst = 1'b1; in_rst = 1'b1;
        @(negedge clk);
        check("R7 reset wins out", 32'(pin_out), 32'h0);
        check("R7 reset wins oe",  32'(pin_oe),  32'h0);
        check("R7 reset wins in",  32'(in_q),    32'h0);
        quiet();

        // R6: neighbour shifts
        out_ce = 1'b1; in_ce = 1'b1;
        out_from_lo = 4'h9; out_from_hi = 4'h6; in_from_lo = 4'h3; in_from_hi = 4'hB;
        out_shift = 2'b01; in_shift = 2'b10;
        @(negedge clk);
        check("R6 out from n-1", 32'(pin_out), 32'h9);
        check("R6 in from n+1",  32'(in_q),    32'hB);
        out_shift = 2'b10; in_shift = 2'b01;
        @(negedge clk);
        check("R6 out from n+1", 32'(pin_out), 32'h6);
        check("R6 in from n-1",  32'(in_q),    32'h3);
        out_shift = 2'b11; in_shift = 2'b11; mux_src = 16'h1111; in_d = 4'h8;
        out_from_lo = 4'h1; out_from_hi = 4'h2; in_from_lo = 4'h4; in_from_hi = 4'h5;
        @(negedge clk);
        check("R6 out hold code", 32'(pin_out), 32'h6);
        check("R6 in hold code",  32'(in_q),    32'h3);
        quiet();

        // R5: latch mode on the output element
        out_latch = 1'b1; out_ce = 1'b1; mux_sel = 2'd0; mux_src = 16'h0007;
        @(posedge clk); #1;
        check("R5 transparent high", 32'(pin_out), 32'h7);
        #1 mux_src = 16'h000B;
        #1 check("R5 follows while high", 32'(pin_out), 32'hB);
        @(negedge clk); #1 mux_src = 16'h0002;
        #1 check("R5 holds while low", 32'(pin_out), 32'hB);
        @(negedge clk);
        quiet();

        // R8: global reset over sets and enables
        out_set = 1'b1; oe_set = 1'b1; in_set = 1'b1;
        @(negedge clk);
        rst_n = 1'b0; out_ce = 1'b1; oe_ce = 1'b1; in_ce = 1'b1;
        @(negedge clk);
        check("R8 pin_out cleared", 32'(pin_out), 32'h0);
        check("R8 pin_oe cleared",  32'(pin_oe),  32'h0);
        check("R8 in_q cleared",    32'(in_q),    32'h0);
        quiet();
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule